// File: doc/BRIEF.md
# Banked Latched Interrupt Hub

This block collects event lines from the functions of a mixed-function peripheral chip and turns them into a single active-high interrupt request. The event lines are split into byte-wide groups. Each group has three registers: one that shows the live level of its eight lines, one that holds sticky pending bits, and one that holds mask bits. Software reaches all of them over a byte-wide register bus. Each bus address is a 16-bit value: the upper byte selects a bank and the lower byte selects a register within it.

A rising edge on an event line sets its pending bit. A read of a group's pending register returns the bits and clears them. The interrupt output is raised when any pending bit is set and its mask bit is clear. The implemented groups occupy only some of the register offsets. One group exists only on chip revisions 0x20 and later, and a parameter selects the revision at build time.

The register bus is a plain synchronous port with no back-pressure. It accepts a request on every cycle. Writes take effect at the next clock edge. Read data comes back one cycle after the request, with a valid strobe. No ready signal is provided, so the host must not expect a read to stall.

Top module: `evt_irq_hub`

## Requirements
- R1: The interrupt registers live in bank 0x0E, which is the address upper byte. Within that bank, group g (zero-based) has its level register at offset 0x00+P(g), its pending register at 0x20+P(g) and its mask register at 0x40+P(g). P is the list 0,1,2,3,4,6,7,8,9,11,18,19,20,21. Bit b of group g is event line evt_i[8*g+b].
- R2: A pending bit is set at the clock edge where its event line is first sampled high after being low. A line that stays high sets the bit only once.
- R3: A read of a pending register returns the bits held before that read and clears them. If a rising edge occurs in the same cycle as the read, that bit is set again after the read.
- R4: A mask bit of 1 blocks its line and a mask bit of 0 lets it through. After reset, every mask register reads 0xFF, every pending register reads 0x00 and irq_o is low.
- R5: irq_o is registered. It is high in the cycle after any group holds a pending bit whose mask bit is 0, and low in the cycle after no such bit exists.
- R6: A level register returns the value of its eight event lines in the cycle of the read request. Writes to a level register are ignored.
- R7: The group at offset 11 exists only when REVISION is 0x20 or higher. On earlier revisions, all of its registers read 0x00, writes to them are ignored, and its events never raise irq_o.
- R8: Offset 0x80 of bank REV_BANK (default 0x08) reads back REVISION. Valid REVISION values are 0x00, 0x10, 0x11, 0x20 and 0x30.
- R9: A read from any other address returns 0x00. A write to any other address changes no register.
- R10: rdata_vld_o is high exactly in the cycle after rd_en_i was high, and rdata_o carries the read result in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_GRP*8 | Event lines, dense numbering (group*8+bit) |
| addr_i | input | 16 | Register address: bank in [15:8], offset in [7:0] |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, valid with rdata_vld_o |
| rdata_vld_o | output | 1 | Read data valid, one cycle after rd_en_i |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
A pending register can be read in the same cycle that a new rising edge arrives on one of its lines, so clear and set fall on one clock edge. The bench forces this case directly: it raises one line of a group while it reads that group's pending register. It then checks two things. The read must return only the earlier bits. A second read must show that the new bit survived. The random phase mixes sparse event toggles with pending reads and mask writes, so this collision also occurs many times on random groups. Every read value and the interrupt level are compared each cycle against a model built from the requirements.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  localparam int unsigned BYTE_W = 8;

  localparam logic [7:0] SRC_BASE   = 8'h00;
  localparam logic [7:0] LATCH_BASE = 8'h20;
  localparam logic [7:0] MASK_BASE  = 8'h40;
  localparam logic [7:0] REV_OFS    = 8'h80;

  typedef enum logic [2:0] {
    REG_NONE,
    REG_SRC,
    REG_LATCH,
    REG_MASK,
    REG_REV
  } reg_kind_e;

  // Sparse register offset of the implemented group at dense index idx.
  function automatic logic [7:0] grp_offset(input int unsigned idx);
    if (idx < 5)       return 8'(idx);
    else if (idx < 9)  return 8'(idx + 1);
    else if (idx == 9) return 8'd11;
    else               return 8'(idx + 8);
  endfunction

  // A group is removed when it sits at the gated offset on an early revision.
  function automatic bit grp_present(input int unsigned idx,
                                     input logic [7:0] gated_ofs,
                                     input logic [7:0] rev,
                                     input logic [7:0] min_rev);
    return !((grp_offset(idx) == gated_ofs) && (rev < min_rev));
  endfunction

endpackage

// File: rtl/evt_irq_decode.sv
module evt_irq_decode
  import evt_irq_pkg::*;
#(
  parameter int unsigned NUM_GRP      = 14,
  parameter int unsigned IDX_W        = 4,
  parameter logic [7:0]  IRQ_BANK     = 8'h0E,
  parameter logic [7:0]  REV_BANK     = 8'h08,
  parameter logic [7:0]  REVISION     = 8'h30,
  parameter logic [7:0]  GATED_OFS    = 8'd11,
  parameter logic [7:0]  GATE_MIN_REV = 8'h20
) (
  input  logic [15:0]      addr_i,
  output reg_kind_e        kind_o,
  output logic [IDX_W-1:0] idx_o
);

  logic [7:0] bank;
  logic [7:0] ofs;

  assign bank = addr_i[15:8];
  assign ofs  = addr_i[7:0];

  always_comb begin
    kind_o = REG_NONE;
    idx_o  = '0;
    if (bank == REV_BANK && ofs == REV_OFS) begin
      kind_o = REG_REV;
    end else if (bank == IRQ_BANK) begin
      for (int unsigned g = 0; g < NUM_GRP; g++) begin
        if (grp_present(g, GATED_OFS, REVISION, GATE_MIN_REV)) begin
          if (ofs == 8'(SRC_BASE + grp_offset(g))) begin
            kind_o = REG_SRC;
            idx_o  = IDX_W'(g);
          end
          if (ofs == 8'(LATCH_BASE + grp_offset(g))) begin
            kind_o = REG_LATCH;
            idx_o  = IDX_W'(g);
          end
          if (ofs == 8'(MASK_BASE + grp_offset(g))) begin
            kind_o = REG_MASK;
            idx_o  = IDX_W'(g);
          end
        end
      end
    end
  end

endmodule

// File: rtl/evt_irq_group.sv
module evt_irq_group #(
  parameter bit PRESENT = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] evt_i,
  input  logic       mask_we_i,
  input  logic [7:0] wdata_i,
  input  logic       latch_rd_i,
  output logic [7:0] src_o,
  output logic [7:0] latch_o,
  output logic [7:0] mask_o,
  output logic       pend_o
);

  logic [7:0] evt_q;
  logic [7:0] latch_q;
  logic [7:0] mask_q;
  logic [7:0] rise;
  logic [7:0] gate;

  assign gate = {8{PRESENT}};
  assign rise = evt_i & ~evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q   <= 8'h00;
      latch_q <= 8'h00;
      mask_q  <= 8'hFF;
    end else begin
      evt_q <= evt_i;
      if (PRESENT) begin
        // set has priority over the read clear
        latch_q <= (latch_rd_i ? 8'h00 : latch_q) | rise;
        if (mask_we_i) mask_q <= wdata_i;
      end
    end
  end

  assign src_o   = evt_i & gate;
  assign latch_o = latch_q & gate;
  assign mask_o  = mask_q & gate;
  assign pend_o  = |(latch_q & ~mask_q & gate);

  // R2
  rise_sets_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (PRESENT && (|rise)) |=> ((latch_q & $past(rise)) == $past(rise)));

  // R3
  rd_clears_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (PRESENT && latch_rd_i) |=> ((latch_q & ~$past(rise)) == 8'h00));

  // R4
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_we_i |=> $stable(mask_q));

endmodule

// File: rtl/evt_irq_merge.sv
module evt_irq_merge #(
  parameter int unsigned NUM_GRP = 14
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_GRP-1:0] pend_i,
  output logic               irq_o
);

  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |pend_i;
  end

  assign irq_o = irq_q;

  // R5
  irq_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pend_i) |=> irq_o);

  // R5
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|pend_i) |=> !irq_o);

endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub
  import evt_irq_pkg::*;
#(
  parameter int unsigned NUM_GRP      = 14,
  parameter logic [7:0]  IRQ_BANK     = 8'h0E,
  parameter logic [7:0]  REV_BANK     = 8'h08,
  parameter logic [7:0]  REVISION     = 8'h30,
  parameter logic [7:0]  GATED_OFS    = 8'd11,
  parameter logic [7:0]  GATE_MIN_REV = 8'h20
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_GRP*BYTE_W-1:0] evt_i,
  input  logic [15:0]               addr_i,
  input  logic [7:0]                wdata_i,
  input  logic                      wr_en_i,
  input  logic                      rd_en_i,
  output logic [7:0]                rdata_o,
  output logic                      rdata_vld_o,
  output logic                      irq_o
);

  localparam int unsigned IDX_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;

  reg_kind_e          kind;
  logic [IDX_W-1:0]   idx;
  logic [NUM_GRP-1:0] mask_we;
  logic [NUM_GRP-1:0] latch_rd;
  logic [NUM_GRP-1:0] pend;
  logic [7:0]         src_a   [NUM_GRP];
  logic [7:0]         latch_a [NUM_GRP];
  logic [7:0]         mask_a  [NUM_GRP];
  logic [7:0]         rd_mux;
  logic [7:0]         rdata_q;
  logic               vld_q;

  evt_irq_decode #(
    .NUM_GRP(NUM_GRP), .IDX_W(IDX_W), .IRQ_BANK(IRQ_BANK), .REV_BANK(REV_BANK),
    .REVISION(REVISION), .GATED_OFS(GATED_OFS), .GATE_MIN_REV(GATE_MIN_REV)
  ) u_dec (
    .addr_i (addr_i),
    .kind_o (kind),
    .idx_o  (idx)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam bit PRES = grp_present(g, GATED_OFS, REVISION, GATE_MIN_REV);

    assign mask_we[g]  = wr_en_i && (kind == REG_MASK)  && (idx == IDX_W'(g));
    assign latch_rd[g] = rd_en_i && (kind == REG_LATCH) && (idx == IDX_W'(g));

    evt_irq_group #(.PRESENT(PRES)) u_grp (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .evt_i      (evt_i[g*BYTE_W +: BYTE_W]),
      .mask_we_i  (mask_we[g]),
      .wdata_i    (wdata_i),
      .latch_rd_i (latch_rd[g]),
      .src_o      (src_a[g]),
      .latch_o    (latch_a[g]),
      .mask_o     (mask_a[g]),
      .pend_o     (pend[g])
    );
  end

  evt_irq_merge #(.NUM_GRP(NUM_GRP)) u_merge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (pend),
    .irq_o  (irq_o)
  );

  always_comb begin
    rd_mux = 8'h00;
    case (kind)
      REG_SRC:   rd_mux = src_a[idx];
      REG_LATCH: rd_mux = latch_a[idx];
      REG_MASK:  rd_mux = mask_a[idx];
      REG_REV:   rd_mux = REVISION;
      default:   rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= 8'h00;
      vld_q   <= 1'b0;
    end else begin
      rdata_q <= rd_en_i ? rd_mux : 8'h00;
      vld_q   <= rd_en_i;
    end
  end

  assign rdata_o     = rdata_q;
  assign rdata_vld_o = vld_q;

  // R10
  rd_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rdata_vld_o);

  // R10
  no_spurious_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rdata_vld_o);

  // R9
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && kind == REG_NONE) |=> (rdata_o == 8'h00));

  // R8
  rev_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && kind == REG_REV) |=> (rdata_o == REVISION));

endmodule

// File: tb/evt_irq_hub_tb_top.sv
module evt_irq_hub_tb_top;

  localparam int NG = 14;
  localparam int EW = NG * 8;
  localparam time TCK = 20ns;

  localparam int OP_IDLE = 0, OP_RDLAT = 1, OP_RDMSK = 2, OP_WRMSK = 3, OP_RDSRC = 4,
                 OP_WRSRC = 5, OP_RDUNM = 6, OP_WRUNM = 7, OP_RDREV = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(TCK/2) clk = ~clk;

  // main instance, late revision
  logic [EW-1:0] evt = '0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  rdata;
  logic        rdata_vld, irq;

  evt_irq_hub #(.REVISION(8'h30)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .addr_i(addr), .wdata_i(wdata),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .rdata_o(rdata), .rdata_vld_o(rdata_vld), .irq_o(irq));

  // second instance, early revision
  logic [EW-1:0] evt2 = '0;
  logic [15:0] addr2 = '0;
  logic [7:0]  wdata2 = '0;
  logic        wr2 = 1'b0, rd2 = 1'b0;
  logic [7:0]  rdata2;
  logic        vld2, irq2;

  evt_irq_hub #(.REVISION(8'h11)) dut_lo_i (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt2), .addr_i(addr2), .wdata_i(wdata2),
    .wr_en_i(wr2), .rd_en_i(rd2), .rdata_o(rdata2), .rdata_vld_o(vld2), .irq_o(irq2));

  int n_chk = 0;
  int n_fail = 0;

  // reference model
  logic [7:0]    m_latch [NG];
  logic [7:0]    m_mask  [NG];
  logic [EW-1:0] m_prev;
  logic          exp_irq;
  logic          exp_vld;
  logic [7:0]    exp_rd;
  string         exp_tag;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", req, act, exp, $time);
    end
  endtask

  // R1: sparse offset list, independent of the design's decoder
  function automatic logic [7:0] ofs_of(input int g);
    case (g)
      0: return 8'd0;   1: return 8'd1;   2: return 8'd2;   3: return 8'd3;
      4: return 8'd4;   5: return 8'd6;   6: return 8'd7;   7: return 8'd8;
      8: return 8'd9;   9: return 8'd11;  10: return 8'd18; 11: return 8'd19;
      12: return 8'd20; default: return 8'd21;
    endcase
  endfunction

  // R9: addresses that map to nothing
  function automatic logic [15:0] unm_addr(input int k);
    case (k)
      0: return 16'h0E05; 1: return 16'h0E0A; 2: return 16'h0E2C; 3: return 16'h0E4A;
      4: return 16'h0E1F; 5: return 16'h0F20; 6: return 16'h0E80; default: return 16'h0E60;
    endcase
  endfunction

  function automatic logic any_pend();
    logic a = 1'b0;
    for (int g = 0; g < NG; g++) a |= |(m_latch[g] & ~m_mask[g]);
    return a;
  endfunction

  task automatic step(input logic [EW-1:0] ev, input int op, input int g,
                      input logic [7:0] wd, input int uk);
    logic [EW-1:0] rise;
    logic [7:0]    clr [NG];
    @(negedge clk);
    check("R5 irq", {7'd0, irq}, {7'd0, exp_irq});
    check("R10 vld", {7'd0, rdata_vld}, {7'd0, exp_vld});
    if (exp_vld) check(exp_tag, rdata, exp_rd);
    evt = ev; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = wd;
    exp_irq = any_pend();
    exp_vld = 1'b0; exp_rd = 8'h00; exp_tag = "";
    rise = ev & ~m_prev;
    for (int i = 0; i < NG; i++) clr[i] = 8'h00;
    case (op)
      OP_RDLAT: begin addr = {8'h0E, 8'h20 + ofs_of(g)}; rd_en = 1'b1; exp_vld = 1'b1;
                      exp_rd = m_latch[g]; clr[g] = 8'hFF; exp_tag = "R3 pending read"; end
      OP_RDMSK: begin addr = {8'h0E, 8'h40 + ofs_of(g)}; rd_en = 1'b1; exp_vld = 1'b1;
                      exp_rd = m_mask[g]; exp_tag = "R4 mask read"; end
      OP_WRMSK: begin addr = {8'h0E, 8'h40 + ofs_of(g)}; wr_en = 1'b1; end
      OP_RDSRC: begin addr = {8'h0E, 8'h00 + ofs_of(g)}; rd_en = 1'b1; exp_vld = 1'b1;
                      exp_rd = ev[g*8 +: 8]; exp_tag = "R6 level read"; end
      OP_WRSRC: begin addr = {8'h0E, 8'h00 + ofs_of(g)}; wr_en = 1'b1; end
      OP_RDUNM: begin addr = unm_addr(uk); rd_en = 1'b1; exp_vld = 1'b1;
                      exp_rd = 8'h00; exp_tag = "R9 unmapped read"; end
      OP_WRUNM: begin addr = unm_addr(uk); wr_en = 1'b1; end
      OP_RDREV: begin addr = 16'h0880; rd_en = 1'b1; exp_vld = 1'b1;
                      exp_rd = 8'h30; exp_tag = "R8 revision read"; end
      default: ;
    endcase
    for (int i = 0; i < NG; i++) begin
      m_latch[i] = (m_latch[i] & ~clr[i]) | rise[i*8 +: 8];
      if (op == OP_WRMSK && i == g) m_mask[i] = wd;
    end
    m_prev = ev;
  endtask

  task automatic lo_cycle(input logic [EW-1:0] ev, input logic [15:0] a,
                          input logic rd, input logic wr, input logic [7:0] wd);
    evt2 = ev; addr2 = a; rd2 = rd; wr2 = wr; wdata2 = wd;
    @(negedge clk);
    rd2 = 1'b0; wr2 = 1'b0;
  endtask

  initial begin
    #(TCK * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [EW-1:0] ev;
    logic [EW-1:0] one;
    void'($urandom(32'h5EED_0E11));
    for (int i = 0; i < NG; i++) begin m_latch[i] = 8'h00; m_mask[i] = 8'hFF; end
    m_prev = '0; exp_irq = 1'b0; exp_vld = 1'b0; exp_rd = 8'h00; exp_tag = "";
    repeat (4) @(negedge clk);
    // R4 reset state
    check("R4 reset irq", {7'd0, irq}, 8'h00);
    check("R10 reset vld", {7'd0, rdata_vld}, 8'h00);
    rst_n = 1'b1;

    ev = '0;
    step(ev, OP_RDMSK, 0, 8'h00, 0);   // R4 reset mask
    step(ev, OP_RDMSK, 13, 8'h00, 0);
    step(ev, OP_RDLAT, 9, 8'h00, 0);   // R4 reset pending
    step(ev, OP_WRMSK, 2, 8'h00, 0);   // unmask group 2
    one = '0; one[17] = 1'b1; ev = one;
    step(ev, OP_IDLE, 0, 8'h00, 0);    // R2 rise on line 17
    step(ev, OP_IDLE, 0, 8'h00, 0);    // R2 held high, no new set
    step(ev, OP_RDLAT, 2, 8'h00, 0);   // R3 returns 0x02, clears
    step(ev, OP_IDLE, 0, 8'h00, 0);
    ev[18] = 1'b1;
    step(ev, OP_IDLE, 0, 8'h00, 0);
    ev[19] = 1'b1;
    step(ev, OP_RDLAT, 2, 8'h00, 0);   // R3 collision: returns 0x04, keeps 0x08
    step(ev, OP_RDLAT, 2, 8'h00, 0);   // R3 returns 0x08
    ev = '0; ev[40] = 1'b1;            // group 5 still masked
    step(ev, OP_IDLE, 0, 8'h00, 0);
    step(ev, OP_IDLE, 0, 8'h00, 0);    // R4 masked line, irq low
    step(ev, OP_RDLAT, 5, 8'h00, 0);
    ev = '0; ev[72] = 1'b1;            // R1 line 72 is group at offset 11
    step(ev, OP_IDLE, 0, 8'h00, 0);
    step(ev, OP_RDLAT, 9, 8'h00, 0);
    step(ev, OP_WRSRC, 1, 8'hFF, 0);   // R6 write ignored
    step(ev, OP_RDSRC, 9, 8'h00, 0);
    step(ev, OP_RDSRC, 1, 8'h00, 0);
    step(ev, OP_WRUNM, 0, 8'h00, 3);   // R9 write ignored
    step(ev, OP_RDMSK, 8, 8'h00, 0);
    step(ev, OP_RDUNM, 0, 8'h00, 5);
    step(ev, OP_RDREV, 0, 8'h00, 0);   // R8

    for (int n = 0; n < 4000; n++) begin
      logic [127:0] flip;
      int op;
      flip = {$urandom & $urandom & $urandom & $urandom, $urandom & $urandom & $urandom & $urandom,
              $urandom & $urandom & $urandom & $urandom, $urandom & $urandom & $urandom & $urandom};
      ev = ev ^ flip[EW-1:0];
      op = int'($urandom_range(0, 8));
      step(ev, op, int'($urandom_range(0, NG-1)), 8'($urandom & $urandom),
           int'($urandom_range(0, 7)));
    end
    step('0, OP_IDLE, 0, 8'h00, 0);
    step('0, OP_IDLE, 0, 8'h00, 0);

    // R7 early revision: group at offset 11 is absent
    @(negedge clk);
    one = '0; one[72] = 1'b1;
    lo_cycle('0, 16'h0E4B, 1'b0, 1'b1, 8'h00);
    lo_cycle('0, 16'h0E40, 1'b0, 1'b1, 8'h00);
    lo_cycle(one, 16'h0000, 1'b0, 1'b0, 8'h00);
    lo_cycle(one, 16'h0000, 1'b0, 1'b0, 8'h00);
    lo_cycle(one, 16'h0000, 1'b0, 1'b0, 8'h00);
    check("R7 absent group irq", {7'd0, irq2}, 8'h00);
    lo_cycle(one, 16'h0E2B, 1'b1, 1'b0, 8'h00);
    check("R7 absent pending", rdata2, 8'h00);
    lo_cycle(one, 16'h0E4B, 1'b1, 1'b0, 8'h00);
    check("R7 absent mask", rdata2, 8'h00);
    lo_cycle(one, 16'h0E0B, 1'b1, 1'b0, 8'h00);
    check("R7 absent level", rdata2, 8'h00);
    lo_cycle('0, 16'h0880, 1'b1, 1'b0, 8'h00);
    check("R8 early revision", rdata2, 8'h11);
    one = '0; one[0] = 1'b1;
    lo_cycle(one, 16'h0000, 1'b0, 1'b0, 8'h00);
    lo_cycle(one, 16'h0000, 1'b0, 1'b0, 8'h00);
    check("R7 present group irq", {7'd0, irq2}, 8'h01);
    lo_cycle('0, 16'h0E40, 1'b1, 1'b0, 8'h00);
    check("R7 present group mask", rdata2, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule